// File: doc/BRIEF.md
# Trigger-Window Watchdog with Hysteresis

This block supervises a periodic trigger produced by a microcontroller. Time is measured in ticks of an independent time base, which enters as a one-cycle enable strobe in the system clock domain. The trigger input passes through a two-flop synchronizer. Each rising edge ends the current measurement and starts the next one. The length of the period just ended, counted in ticks, is then judged against a window: too short is bad, too long is bad, and anything inside the window is good. The nominal period is 100 ticks.

The verdicts feed a vote counter that saturates at 0 and at 3. A good verdict moves it up by one and a bad verdict moves it down by one. An ok flag is set when the vote reaches 3 and cleared when it reaches 0, and it holds its value at 1 and 2. Three good periods in a row therefore release the enable output, and three bad periods in a row lock it again. While the flag is set, both window bounds are one tick lower. This gives the margins hysteresis. If 250 ticks pass with no edge, the vote and the flag are cleared at once. A synchronous reset from the supply monitor returns the block to its initial state, as does the asynchronous system reset.

Top module: `trigwin_watchdog`

## Requirements
- R1: A rising edge of `trig_in` acts on the period measurement two clock cycles after the cycle in which `trig_in` is first sampled high. Each edge restarts the measurement.
- R2: The first edge after reset, after a supply reset or after a timeout only starts a measurement. No verdict is produced for it (`class_valid` stays 0).
- R3: On every later edge, `class_valid` is 1 for exactly the one cycle after the edge acts. `class_good` is 1 when the measured period lies inside the window and 0 when it does not.
- R4: While `wd_ok` is 0 the window is 80 to 170 ticks, inclusive. While `wd_ok` is 1 it is 79 to 169 ticks, inclusive. The bounds are taken from the value of `wd_ok` in the cycle of the edge.
- R5: The vote moves up on a good verdict and down on a bad verdict, and it saturates at 3 and at 0. After a run of more than three good periods, three bad periods are enough to clear `wd_ok`.
- R6: `wd_ok` becomes 1 in the same cycle as the verdict that brings the vote to 3. It becomes 0 with the verdict that brings the vote to 0. At every other vote value it keeps its previous value.
- R7: `enable_out` equals `wd_ok` in every cycle.
- R8: If the tick count since the last edge reaches 250, the vote and `wd_ok` are cleared in that cycle and the next edge is not classified. `wd_ok` is still 1 after 249 ticks.
- R9: A cycle with `supply_rst` = 1 clears the vote, `wd_ok` and the measurement.
- R10: While `rst_n` is low, `wd_ok`, `enable_out` and `class_valid` are 0.
- R11: Only cycles with `tick` = 1 count toward a period. A tick in the cycle an edge acts counts as the first tick of the new period. Cycles without a tick have no effect on the verdict or on the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_rst | input | 1 | Synchronous reset from the supply monitor |
| tick | input | 1 | One-cycle time-base strobe |
| trig_in | input | 1 | Asynchronous trigger from the microcontroller |
| wd_ok | output | 1 | Watchdog healthy flag |
| enable_out | output | 1 | Enable, follows `wd_ok` |
| class_valid | output | 1 | One-cycle strobe, a verdict is present |
| class_good | output | 1 | Verdict, 1 = period inside window |

## Verification
The hardest cases to reach are the one-tick hysteresis margins. A period of 79 or 170 ticks is judged differently depending on whether `wd_ok` is set when the edge arrives. Reaching them takes a vote history built up beforehand, plus edges placed on an exact tick count. The stimulus runs the tick strobe on a fixed two-cycle pattern and raises the trigger always at the same tick phase. A requested period length is then exactly the measured one. Sequences first raise the flag, then drop it, and apply each margin period in both states. A behavioural model compares every output on every clock.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  localparam int unsigned VOTE_W = 2;

  typedef logic [VOTE_W-1:0] wwd_vote_t;

  localparam wwd_vote_t VOTE_TOP  = wwd_vote_t'(3);
  localparam wwd_vote_t VOTE_ZERO = wwd_vote_t'(0);

  typedef struct packed {
    logic valid;
    logic good;
  } wwd_verdict_t;

  typedef enum logic [1:0] {
    VS_HOLD  = 2'd0,
    VS_UP    = 2'd1,
    VS_DOWN  = 2'd2,
    VS_CLEAR = 2'd3
  } wwd_vote_op_t;

endpackage

// File: rtl/wwd_edge_sync.sv
module wwd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sh_q;
  logic [DEPTH-1:0] sh_d;

  // shift chain: STAGES synchronizer flops plus one history flop
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_chain
      if (i == 0) begin : g_head
        always_comb sh_d[i] = din;
      end else begin : g_body
        always_comb sh_d[i] = sh_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R1: a detected edge lasts a single cycle
  p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/wwd_period_timer.sv
module wwd_period_timer
  import wwd_pkg::*;
#(
  parameter int unsigned LO_CLR  = 80,
  parameter int unsigned LO_SET  = 79,
  parameter int unsigned HI_CLR  = 170,
  parameter int unsigned HI_SET  = 169,
  parameter int unsigned TIMEOUT = 250
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic         rise_i,
  input  logic         ok_i,
  output wwd_verdict_t verdict_o,
  output wwd_verdict_t verdict_q_o,
  output logic         timeout_o
);

  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LO_CLR_C = CW'(LO_CLR);
  localparam logic [CW-1:0] LO_SET_C = CW'(LO_SET);
  localparam logic [CW-1:0] HI_CLR_C = CW'(HI_CLR);
  localparam logic [CW-1:0] HI_SET_C = CW'(HI_SET);
  localparam logic [CW-1:0] LAST_C   = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] ONE_C    = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  wwd_verdict_t  verdict_q, verdict_d;
  logic [CW-1:0] lo_bound, hi_bound;
  logic          in_window;
  logic          count_en;

  // window bounds shift with the ok flag
  always_comb begin
    lo_bound  = ok_i ? LO_SET_C : LO_CLR_C;
    hi_bound  = ok_i ? HI_SET_C : HI_CLR_C;
    in_window = (cnt_q >= lo_bound) && (cnt_q <= hi_bound);
  end

  always_comb begin
    count_en        = tick_i & armed_q;
    timeout_o       = ~clr_i & ~rise_i & count_en & (cnt_q == LAST_C);
    verdict_d.valid = ~clr_i & rise_i & armed_q;
    verdict_d.good  = ~clr_i & rise_i & armed_q & in_window;
  end

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (clr_i) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (rise_i) begin
      cnt_d   = tick_i ? ONE_C : '0;
      armed_d = 1'b1;
    end else if (timeout_o) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (count_en) begin
      cnt_d   = cnt_q + ONE_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      verdict_q <= '0;
    end else begin
      cnt_q     <= cnt_d;
      armed_q   <= armed_d;
      verdict_q <= verdict_d;
    end
  end

  assign verdict_o   = verdict_d;
  assign verdict_q_o = verdict_q;

  // R1: an edge always leaves a freshly armed, restarted measurement
  p_rise_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !clr_i) |=> (armed_q && cnt_q <= ONE_C));

  // R2: an edge that finds the timer disarmed yields no verdict
  p_first_unclassified_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !armed_q) |=> !verdict_q.valid);

  // R8: a timeout disarms the timer
  p_timeout_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> (!armed_q && cnt_q == '0));

  // R9: supply reset clears the measurement
  p_clear_meas_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!armed_q && !verdict_q.valid));

endmodule

// File: rtl/wwd_vote.sv
module wwd_vote
  import wwd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         timeout_i,
  input  wwd_verdict_t verdict_i,
  output logic         ok_o
);

  wwd_vote_op_t op;
  wwd_vote_t    lvl_q, lvl_d;
  logic         ok_q, ok_d;

  always_comb begin
    if (clr_i || timeout_i) begin
      op = VS_CLEAR;
    end else if (verdict_i.valid && verdict_i.good) begin
      op = VS_UP;
    end else if (verdict_i.valid) begin
      op = VS_DOWN;
    end else begin
      op = VS_HOLD;
    end
  end

  always_comb begin
    lvl_d = lvl_q;
    unique case (op)
      VS_UP:    lvl_d = (lvl_q == VOTE_TOP)  ? lvl_q : lvl_q + wwd_vote_t'(1);
      VS_DOWN:  lvl_d = (lvl_q == VOTE_ZERO) ? lvl_q : lvl_q - wwd_vote_t'(1);
      VS_CLEAR: lvl_d = VOTE_ZERO;
      default:  lvl_d = lvl_q;
    endcase
  end

  always_comb begin
    if (op == VS_CLEAR) begin
      ok_d = 1'b0;
    end else if (lvl_d == VOTE_TOP) begin
      ok_d = 1'b1;
    end else if (lvl_d == VOTE_ZERO) begin
      ok_d = 1'b0;
    end else begin
      ok_d = ok_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= VOTE_ZERO;
      ok_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      ok_q  <= ok_d;
    end
  end

  assign ok_o = ok_q;

  // R5: without a clear the vote moves by at most one step
  p_vote_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op != VS_CLEAR) |=> ((lvl_q == $past(lvl_q)) ||
                          (int'(lvl_q) == int'($past(lvl_q)) + 1) ||
                          (int'(lvl_q) + 1 == int'($past(lvl_q)))));

  // R6: flag and vote agree at the two ends
  p_ok_at_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == VOTE_TOP) |-> ok_q);
  p_ok_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == VOTE_ZERO) |-> !ok_q);

  // R6: the flag rises only after a good verdict
  p_ok_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(op == VS_UP));

  // R8: a clear empties the vote and drops the flag
  p_clear_vote_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == VS_CLEAR) |=> (lvl_q == VOTE_ZERO && !ok_q));

endmodule

// File: rtl/trigwin_watchdog.sv
module trigwin_watchdog
  import wwd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LO_CLR      = 80,
  parameter int unsigned LO_SET      = 79,
  parameter int unsigned HI_CLR      = 170,
  parameter int unsigned HI_SET      = 169,
  parameter int unsigned TIMEOUT     = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_rst,
  input  logic tick,
  input  logic trig_in,
  output logic wd_ok,
  output logic enable_out,
  output logic class_valid,
  output logic class_good
);

  logic         rise;
  logic         timeout;
  logic         ok;
  wwd_verdict_t verdict_now;
  wwd_verdict_t verdict_reg;

  wwd_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (trig_in),
    .rise_o (rise)
  );

  wwd_period_timer #(
    .LO_CLR  (LO_CLR),
    .LO_SET  (LO_SET),
    .HI_CLR  (HI_CLR),
    .HI_SET  (HI_SET),
    .TIMEOUT (TIMEOUT)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (supply_rst),
    .tick_i      (tick),
    .rise_i      (rise),
    .ok_i        (ok),
    .verdict_o   (verdict_now),
    .verdict_q_o (verdict_reg),
    .timeout_o   (timeout)
  );

  wwd_vote u_vote (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (supply_rst),
    .timeout_i (timeout),
    .verdict_i (verdict_now),
    .ok_o      (ok)
  );

  assign wd_ok       = ok;
  assign enable_out  = ok;
  assign class_valid = verdict_reg.valid;
  assign class_good  = verdict_reg.good;

  // R3: a verdict strobe lasts one cycle
  p_verdict_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid |=> !class_valid);

  // R9: supply reset leaves the flag clear
  p_supply_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    supply_rst |=> !wd_ok);

endmodule

// File: tb/trigwin_watchdog_bench.sv
module trigwin_watchdog_bench;

  localparam int LO_CLR  = 80;
  localparam int LO_SET  = 79;
  localparam int HI_CLR  = 170;
  localparam int HI_SET  = 169;
  localparam int TIMEOUT = 250;

  logic clk;
  logic rst_n;
  logic supply_rst;
  logic tick;
  logic trig_in;
  logic wd_ok;
  logic enable_out;
  logic class_valid;
  logic class_good;

  int checks;
  int failures;
  bit done;

  trigwin_watchdog u_trigwin_watchdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_rst  (supply_rst),
    .tick        (tick),
    .trig_in     (trig_in),
    .wd_ok       (wd_ok),
    .enable_out  (enable_out),
    .class_valid (class_valid),
    .class_good  (class_good)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit m_hist[3];
  int m_ticks;
  bit m_running;
  int m_votes;
  bit m_ok;
  bit m_valid;
  bit m_good;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist    = '{0, 0, 0};
      m_ticks   = 0;
      m_running = 0;
      m_votes   = 0;
      m_ok      = 0;
      m_valid   = 0;
      m_good    = 0;
    end else begin
      bit edge_seen;
      int lo;
      int hi;
      edge_seen = m_hist[1] && !m_hist[2];
      m_hist[2] = m_hist[1];
      m_hist[1] = m_hist[0];
      m_hist[0] = trig_in;
      m_valid   = 0;
      m_good    = 0;
      if (supply_rst) begin
        m_ticks = 0; m_running = 0; m_votes = 0; m_ok = 0;
      end else if (edge_seen) begin
        if (m_running) begin
          lo = m_ok ? LO_SET : LO_CLR;
          hi = m_ok ? HI_SET : HI_CLR;
          m_valid = 1;
          m_good  = (m_ticks >= lo) && (m_ticks <= hi);
          if (m_good) m_votes = (m_votes < 3) ? m_votes + 1 : 3;
          else        m_votes = (m_votes > 0) ? m_votes - 1 : 0;
          if (m_votes == 3) m_ok = 1;
          if (m_votes == 0) m_ok = 0;
        end
        m_running = 1;
        m_ticks   = tick ? 1 : 0;
      end else if (tick && m_running) begin
        m_ticks = m_ticks + 1;
        if (m_ticks >= TIMEOUT) begin
          m_ticks = 0; m_running = 0; m_votes = 0; m_ok = 0;
        end
      end
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(wd_ok == m_ok, "R6 wd_ok", int'(wd_ok), int'(m_ok));
      chk(enable_out == m_ok, "R7 enable_out", int'(enable_out), int'(m_ok));
      chk(class_valid == m_valid, "R3 class_valid", int'(class_valid), int'(m_valid));
      if (m_valid)
        chk(class_good == m_good, "R4 class_good", int'(class_good), int'(m_good));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit tk, input bit tr);
    tick    = tk;
    trig_in = tr;
    @(posedge clk);
    @(negedge clk);
  endtask

  // mode 0: no probe, 1: expect no verdict, 2: expect verdict
  task automatic pulse(input int n, input int mode, input bit exp_good,
                       input bit exp_ok, input string req);
    cyc(1, 1);
    cyc(0, 1);
    cyc(1, 0);
    if (mode == 1) begin
      chk(class_valid == 1'b0, req, int'(class_valid), 0);
    end else if (mode == 2) begin
      chk(class_valid == 1'b1, req, int'(class_valid), 1);
      chk(class_good == exp_good, req, int'(class_good), int'(exp_good));
      chk(wd_ok == exp_ok, req, int'(wd_ok), int'(exp_ok));
    end
    cyc(0, 0);
    for (int i = 0; i < n - 2; i++) begin
      cyc(1, 0);
      cyc(0, 0);
    end
  endtask

  initial begin
    done       = 0;
    checks     = 0;
    failures   = 0;
    rst_n      = 1'b0;
    supply_rst = 1'b0;
    tick       = 1'b0;
    trig_in    = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(wd_ok == 1'b0, "R10 wd_ok", int'(wd_ok), 0);
    chk(enable_out == 1'b0, "R10 enable_out", int'(enable_out), 0);
    chk(class_valid == 1'b0, "R10 class_valid", int'(class_valid), 0);
    rst_n = 1'b1;
    cyc(0, 0);

    pulse(100, 1, 0, 0, "R2 first edge");
    pulse(100, 2, 1, 0, "R3 nominal good");
    pulse(100, 2, 1, 0, "R5 vote 2");
    pulse(79,  2, 1, 1, "R6 release on third good");
    pulse(169, 2, 1, 1, "R4 lower 79 with ok");
    pulse(78,  2, 1, 1, "R4 upper 169 with ok");
    pulse(170, 2, 0, 1, "R3 too fast 78");
    pulse(100, 2, 0, 1, "R4 upper 170 bad with ok");
    pulse(100, 2, 1, 1, "R6 hold");
    pulse(100, 2, 1, 1, "R6 hold");
    pulse(100, 2, 1, 1, "R5 saturate top");
    pulse(60,  2, 1, 1, "R5 saturate top");
    pulse(60,  2, 0, 1, "R5 bad 1");
    pulse(60,  2, 0, 1, "R5 bad 2");
    pulse(100, 2, 0, 0, "R5 three bads lock");
    pulse(79,  2, 1, 0, "R6 vote 1 no release");
    pulse(100, 2, 0, 0, "R4 lower 79 bad without ok");
    pulse(80,  2, 1, 0, "R4 lower 80 good");
    pulse(170, 2, 1, 0, "R4 80 good");
    pulse(100, 2, 1, 1, "R4 upper 170 good without ok");

    // R8: timeout at exactly 250 ticks
    pulse(2, 2, 1, 1, "R8 setup");
    for (int i = 0; i < TIMEOUT - 2; i++) begin
      cyc(1, 0);
      cyc(0, 0);
    end
    chk(wd_ok == 1'b1, "R8 still ok at 249", int'(wd_ok), 1);
    cyc(1, 0);
    chk(wd_ok == 1'b0, "R8 cleared at 250", int'(wd_ok), 0);
    chk(enable_out == 1'b0, "R7 enable after timeout", int'(enable_out), 0);
    cyc(0, 0);
    pulse(100, 1, 0, 0, "R2 first edge after timeout");
    pulse(100, 2, 1, 0, "R8 vote restarted");
    pulse(100, 2, 1, 0, "R5 vote 2");
    pulse(100, 2, 1, 1, "R6 release");

    // R11: idle cycles without tick do not count
    cyc(1, 1);
    cyc(0, 1);
    cyc(1, 0);
    cyc(0, 0);
    for (int i = 0; i < 40; i++) begin
      cyc(1, 0);
      cyc(0, 0);
    end
    repeat (600) cyc(0, 0);
    for (int i = 0; i < 58; i++) begin
      cyc(1, 0);
      cyc(0, 0);
    end
    pulse(100, 2, 1, 1, "R11 idle cycles ignored");

    // R9: supply reset
    supply_rst = 1'b1;
    cyc(0, 0);
    supply_rst = 1'b0;
    chk(wd_ok == 1'b0, "R9 wd_ok cleared", int'(wd_ok), 0);
    pulse(100, 1, 0, 0, "R9 measurement cleared");
    pulse(100, 2, 1, 0, "R9 vote from zero");
    pulse(100, 2, 1, 0, "R9 vote 2");
    pulse(100, 2, 1, 1, "R1 release again");

    // R10: asynchronous reset while ok
    done = 1;
    rst_n = 1'b0;
    #1;
    chk(wd_ok == 1'b0, "R10 async wd_ok", int'(wd_ok), 0);
    chk(enable_out == 1'b0, "R10 async enable", int'(enable_out), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule